// File: doc/BRIEF.md
# Engine Reset and Memory Scrubber

This block controls the reset of a small embedded engine that owns two local memories, one for instructions and one for data. Software reaches it through a small register port. A hold bit in a control register keeps the engine in reset. When software clears that bit, the block writes zero to every word of both memories. It clears one word per cycle in each memory, and the two memories are cleared side by side. A done flag in a status register then rises. The same status word shows a readiness flag and a fixed capability bit that reports whether an alternate RISC-V core is present. A read-only configuration word reports the core revision, its subversion and its security model.

A second port gives direct word access to either memory. The memories are behavioural RAM arrays inside the block. While a scrub is running, writes on this port are dropped and reads on it return zero. The scrub takes as many cycles as the deeper memory has words, which keeps it within a few thousand cycles for the default sizes.

Top module: `engine_scrub_ctrl`

## Requirements
- R1: After `rst_n` is released, both read-data outputs are zero. The control word reads 1 (engine held). The status word reads scrub-done low, ready high, and the capability bit equal to `HAS_ALT_CORE`.
- R2: A register write to address 0 with bit 0 = 1 holds the engine, whatever the ready flag shows at that moment. A write of bit 0 = 0 starts a scrub only if the engine is held. The same write while the engine is already released changes nothing.
- R3: The status word at address 1 has ready in bit 0, scrub-done in bit 1 and the capability bit in bit 2. Scrub-done goes low on the edge that accepts a hold write and stays low until a scrub completes.
- R4: A scrub clears every word of both memories. It ends exactly N edges after the edge that accepted the release write, where N is the depth of the deeper memory. Scrub-done is high from that edge on.
- R5: A hold write during a scrub stops it at once. Scrub-done stays low. Words not yet reached keep their contents. A later release restarts the scrub from word 0 and runs it in full.
- R6: The configuration word at address 2 reads revision in bits [2:0], subversion in bits [5:4] and security model in bits [9:8], taken from the parameters.
- R7: While a scrub is running, host memory writes are ignored and host memory reads return zero.
- R8: Outside a scrub, `mem_sel` picks the memory (0 = instruction, 1 = data). A write stores `mem_wdata`. A read returns the word on `mem_rdata` after the next edge. An address at or beyond the selected memory's depth is ignored on write and reads zero.
- R9: The ready bit reads 0 in a cycle where a scrub is running or a host memory access was issued in the previous cycle. Otherwise it reads 1.
- R10: A register read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 configuration) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, valid after the edge that takes `reg_rd` |
| mem_wr | input | 1 | Host memory write strobe |
| mem_rd | input | 1 | Host memory read strobe |
| mem_sel | input | 1 | Memory select: 0 instruction, 1 data |
| mem_addr | input | MEM_AW | Word address |
| mem_wdata | input | DATA_W | Memory write data |
| mem_rdata | output | DATA_W | Memory read data, valid after the edge that takes `mem_rd` |

## Verification
A wrong scrub index or stop condition shows up at the ports in one of two ways. Scrub-done rises on the wrong cycle, or a word left non-zero is read back through the memory port once the scrub ends. A reference model that tracks every cycle catches either fault on the first read that follows it. A stuck hold bit or a wrong active flag changes the next status or memory read one cycle after the faulty edge, because that read returns a stale word or zero where data was expected. A scrub that is stopped part way is checked by reading back one word that the scrub had already passed and one it had not reached.

// File: rtl/engine_scrub_pkg.sv
package engine_scrub_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_CFG  = 2'd2,
      REG_RSVD = 2'd3
   } esc_reg_e;

   localparam int CTRL_HOLD_BIT = 0;
   localparam int STAT_READY_BIT = 0;
   localparam int STAT_DONE_BIT = 1;
   localparam int STAT_ALT_BIT = 2;
   localparam int CFG_REV_LSB = 0;
   localparam int CFG_SUB_LSB = 4;
   localparam int CFG_SEC_LSB = 8;
   localparam int CFG_MIN_W = 10;

   function automatic logic [31:0] cfg_word(input int rev, input int sub, input int sec);
      logic [31:0] w;
      w = '0;
      w[CFG_REV_LSB +: 3] = 3'(rev);
      w[CFG_SUB_LSB +: 2] = 2'(sub);
      w[CFG_SEC_LSB +: 2] = 2'(sec);
      return w;
   endfunction

endpackage

// File: rtl/esc_regs.sv
module esc_regs
   import engine_scrub_pkg::*;
#(
   parameter int          REG_W    = 32,
   parameter logic [31:0] CFG_WORD = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             stat_ready,
   input  logic             stat_done,
   input  logic             stat_alt,
   output logic [REG_W-1:0] reg_rdata,
   output logic             hold,
   output logic             release_req,
   output logic             assert_req
);

   logic             hold_q;
   logic             wr_ctrl;
   logic [REG_W-1:0] rd_mux;

   assign wr_ctrl     = reg_wr && (esc_reg_e'(reg_addr) == REG_CTRL);
   assign assert_req  = wr_ctrl && reg_wdata[CTRL_HOLD_BIT];
   assign release_req = wr_ctrl && !reg_wdata[CTRL_HOLD_BIT] && hold_q;
   assign hold        = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b1;
      end else if (assert_req) begin
         hold_q <= 1'b1;
      end else if (release_req) begin
         hold_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (esc_reg_e'(reg_addr))
         REG_CTRL: rd_mux[CTRL_HOLD_BIT] = hold_q;
         REG_STAT: begin
            rd_mux[STAT_READY_BIT] = stat_ready;
            rd_mux[STAT_DONE_BIT]  = stat_done;
            rd_mux[STAT_ALT_BIT]   = stat_alt;
         end
         REG_CFG:  rd_mux = REG_W'(CFG_WORD);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         reg_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/esc_scrub_seq.sv
module esc_scrub_seq #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   output logic          active,
   output logic          done,
   output logic [AW-1:0] idx
);

   localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         done   <= 1'b0;
         idx    <= '0;
      end else if (abort) begin
         active <= 1'b0;
         done   <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         done   <= 1'b0;
         idx    <= '0;
      end else if (active) begin
         if (idx == LAST_IDX) begin
            active <= 1'b0;
            done   <= 1'b1;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/esc_local_ram.sv
module esc_local_ram #(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 32,
   parameter int AW     = 10
) (
   input  logic              clk,
   input  logic              scrub_en,
   input  logic [AW-1:0]     scrub_idx,
   input  logic              host_wr,
   input  logic [AW-1:0]     host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   localparam int IW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              host_in;
   logic              scrub_in;

   generate
      if (IW == AW) begin : g_full
         assign host_in  = 1'b1;
         assign scrub_in = 1'b1;
      end else begin : g_part
         assign host_in  = (host_addr[AW-1:IW] == '0);
         assign scrub_in = (scrub_idx[AW-1:IW] == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (scrub_en) begin
         if (scrub_in) begin
            mem[scrub_idx[IW-1:0]] <= '0;
         end
      end else if (host_wr && host_in) begin
         mem[host_addr[IW-1:0]] <= host_wdata;
      end
   end

   assign host_rdata = host_in ? mem[host_addr[IW-1:0]] : '0;

endmodule

// File: rtl/engine_scrub_ctrl.sv
module engine_scrub_ctrl
   import engine_scrub_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int REG_W        = 32,
   parameter int IMEM_DEPTH   = 1024,
   parameter int DMEM_DEPTH   = 512,
   parameter int CORE_REV     = 5,
   parameter int CORE_SUBVER  = 2,
   parameter int SEC_MODEL    = 3,
   parameter bit HAS_ALT_CORE = 1'b1,
   parameter int MEM_AW       = $clog2((IMEM_DEPTH > DMEM_DEPTH) ? IMEM_DEPTH : DMEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              mem_wr,
   input  logic              mem_rd,
   input  logic              mem_sel,
   input  logic [MEM_AW-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] mem_rdata
);

   localparam int          MAX_DEPTH = (IMEM_DEPTH > DMEM_DEPTH) ? IMEM_DEPTH : DMEM_DEPTH;
   localparam int          N_MEM     = 2;
   localparam logic [31:0] CFG_VAL   = cfg_word(CORE_REV, CORE_SUBVER, SEC_MODEL);

   // elaboration-time parameter checks
   generate
      if (CORE_REV < 1 || CORE_REV > 7) begin : g_bad_rev
         $error("CORE_REV must lie in 1..7");
      end
      if (CORE_SUBVER < 0 || CORE_SUBVER > 3) begin : g_bad_sub
         $error("CORE_SUBVER must fit in two bits");
      end
      if (SEC_MODEL != 0 && SEC_MODEL != 2 && SEC_MODEL != 3) begin : g_bad_sec
         $error("SEC_MODEL must be 0, 2 or 3");
      end
      if (IMEM_DEPTH < 2 || (IMEM_DEPTH & (IMEM_DEPTH - 1)) != 0) begin : g_bad_idep
         $error("IMEM_DEPTH must be a power of two of at least 2");
      end
      if (DMEM_DEPTH < 2 || (DMEM_DEPTH & (DMEM_DEPTH - 1)) != 0) begin : g_bad_ddep
         $error("DMEM_DEPTH must be a power of two of at least 2");
      end
      if (REG_W < CFG_MIN_W || REG_W > 32) begin : g_bad_regw
         $error("REG_W must lie between the configuration width and 32");
      end
      if ((1 << MEM_AW) != MAX_DEPTH) begin : g_bad_aw
         $error("MEM_AW must address exactly the deeper memory");
      end
   endgenerate

   logic              hold;
   logic              release_req;
   logic              assert_req;
   logic              scrub_active;
   logic              scrub_done;
   logic [MEM_AW-1:0] scrub_idx;
   logic              busy_q;
   logic              stat_ready;
   logic              stat_alt;
   logic [DATA_W-1:0] rd_word [N_MEM];
   logic [DATA_W-1:0] mem_rdata_q;

   generate
      if (HAS_ALT_CORE) begin : g_alt_on
         assign stat_alt = 1'b1;
      end else begin : g_alt_off
         assign stat_alt = 1'b0;
      end
   endgenerate

   assign stat_ready = !(busy_q || scrub_active);

   esc_regs #(
      .REG_W   (REG_W),
      .CFG_WORD(CFG_VAL)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .stat_ready (stat_ready),
      .stat_done  (scrub_done),
      .stat_alt   (stat_alt),
      .reg_rdata  (reg_rdata),
      .hold       (hold),
      .release_req(release_req),
      .assert_req (assert_req)
   );

   esc_scrub_seq #(
      .AW(MEM_AW)
   ) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (release_req),
      .abort (assert_req),
      .active(scrub_active),
      .done  (scrub_done),
      .idx   (scrub_idx)
   );

   for (genvar g = 0; g < N_MEM; g++) begin : g_mem
      localparam int GDEPTH = (g == 0) ? IMEM_DEPTH : DMEM_DEPTH;
      logic sel_hit;
      assign sel_hit = (mem_sel == 1'(g));
      esc_local_ram #(
         .DEPTH (GDEPTH),
         .DATA_W(DATA_W),
         .AW    (MEM_AW)
      ) ram_i (
         .clk       (clk),
         .scrub_en  (scrub_active),
         .scrub_idx (scrub_idx),
         .host_wr   (mem_wr && !scrub_active && sel_hit),
         .host_addr (mem_addr),
         .host_wdata(mem_wdata),
         .host_rdata(rd_word[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         mem_rdata_q <= '0;
      end else begin
         busy_q <= mem_rd || mem_wr;
         if (mem_rd) begin
            mem_rdata_q <= scrub_active ? '0 : rd_word[mem_sel];
         end
      end
   end

   assign mem_rdata = mem_rdata_q;

endmodule

// File: rtl/engine_scrub_chk.sv
module engine_scrub_chk
   import engine_scrub_pkg::*;
#(
   parameter int AW     = 10,
   parameter int DATA_W = 32,
   parameter int REG_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [1:0]        reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              mem_rd,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              hold,
   input logic              scrub_active,
   input logic              scrub_done
);

   localparam int N_WORDS = 1 << AW;

   logic [AW:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (scrub_active) begin
         run_cnt <= run_cnt + 1'b1;
      end else begin
         run_cnt <= '0;
      end
   end

   assert_release_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_CTRL && !reg_wdata[CTRL_HOLD_BIT] && hold) |=> scrub_active);

   assert_hold_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_CTRL && reg_wdata[CTRL_HOLD_BIT]) |=> (!scrub_done && hold));

   assert_done_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scrub_done) |-> $past(scrub_active));

   assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_active |-> (int'(run_cnt) < N_WORDS));

   assert_no_run_while_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_active |-> !hold);

   assert_read_zero_in_scrub_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && scrub_active) |=> (mem_rdata == '0));

   assert_not_ready_in_scrub_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == REG_STAT && scrub_active) |=> !reg_rdata[STAT_READY_BIT]);

endmodule

bind engine_scrub_ctrl engine_scrub_chk #(
   .AW    (MEM_AW),
   .DATA_W(DATA_W),
   .REG_W (REG_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .mem_rd      (mem_rd),
   .mem_rdata   (mem_rdata),
   .hold        (hold),
   .scrub_active(scrub_active),
   .scrub_done  (scrub_done)
);

// File: tb/engine_scrub_ctrl_tb_top.sv
`timescale 1ns/1ps
module engine_scrub_ctrl_tb_top;

   localparam int DW   = 32;
   localparam int ID   = 1024;
   localparam int DD   = 512;
   localparam int AW   = 10;
   localparam int REV  = 5;
   localparam int SUB  = 2;
   localparam int SEC  = 3;
   localparam bit ALT  = 1'b1;
   localparam int NSCR = (ID > DD) ? ID : DD;
   localparam logic [31:0] CFG_EXP = 32'(REV) | (32'(SUB) << 4) | (32'(SEC) << 8);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_wr = 1'b0, mem_rd = 1'b0, mem_sel = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic [DW-1:0] mem_rdata;

   always #5 clk = ~clk;

   engine_scrub_ctrl #(
      .DATA_W(DW), .REG_W(32), .IMEM_DEPTH(ID), .DMEM_DEPTH(DD),
      .CORE_REV(REV), .CORE_SUBVER(SUB), .SEC_MODEL(SEC), .HAS_ALT_CORE(ALT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
      .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_imem [int];
   logic [31:0] m_dmem [int];
   bit          m_hold, m_active, m_done, m_busy;
   int          m_pos;
   logic [31:0] e_reg, e_mem;
   bit          e_mem_known;
   string       e_reg_req, e_mem_req;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hold = 1'b1; m_active = 1'b0; m_done = 1'b0; m_busy = 1'b0; m_pos = 0;
         e_reg = '0; e_mem = '0; e_mem_known = 1'b1;
         e_reg_req = "R1"; e_mem_req = "R1";
      end else begin
         if (reg_rd) begin
            case (reg_addr)
               2'd0: begin e_reg = {31'b0, m_hold}; e_reg_req = "R2"; end
               2'd1: begin
                  e_reg = {29'b0, ALT, m_done, !(m_busy || m_active)};
                  e_reg_req = "R3/R9";
               end
               2'd2: begin e_reg = CFG_EXP; e_reg_req = "R6"; end
               default: begin e_reg = '0; e_reg_req = "R10"; end
            endcase
         end
         if (mem_rd) begin
            e_mem_known = 1'b1;
            if (m_active) begin
               e_mem = '0; e_mem_req = "R7";
            end else begin
               e_mem_req = "R8";
               if (int'(mem_addr) >= (mem_sel ? DD : ID)) e_mem = '0;
               else if (!mem_sel && m_imem.exists(int'(mem_addr))) e_mem = m_imem[int'(mem_addr)];
               else if (mem_sel && m_dmem.exists(int'(mem_addr))) e_mem = m_dmem[int'(mem_addr)];
               else e_mem_known = 1'b0;
            end
         end
         if (mem_wr && !m_active && int'(mem_addr) < (mem_sel ? DD : ID)) begin
            if (mem_sel) m_dmem[int'(mem_addr)] = mem_wdata;
            else m_imem[int'(mem_addr)] = mem_wdata;
         end
         if (m_active) begin
            if (m_pos < ID) m_imem[m_pos] = '0;
            if (m_pos < DD) m_dmem[m_pos] = '0;
            if (m_pos == NSCR - 1) begin m_active = 1'b0; m_done = 1'b1; end
            else m_pos++;
         end
         if (reg_wr && reg_addr == 2'd0) begin
            if (reg_wdata[0]) begin
               m_hold = 1'b1; m_active = 1'b0; m_done = 1'b0;
            end else if (m_hold) begin
               m_hold = 1'b0; m_active = 1'b1; m_pos = 0; m_done = 1'b0;
            end
         end
         m_busy = mem_rd || mem_wr;
      end
   end

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(e_reg_req, reg_rdata, e_reg);
         if (e_mem_known) check(e_mem_req, mem_rdata, e_mem);
      end
   end

   // ---------------- stimulus tasks (entered at a falling edge) ----------------
   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic mem_write(input logic s, input int a, input logic [31:0] d);
      mem_wr = 1'b1; mem_sel = s; mem_addr = AW'(a); mem_wdata = d;
      @(negedge clk);
      mem_wr = 1'b0;
   endtask

   task automatic mem_read(input logic s, input int a, output logic [31:0] d);
      mem_rd = 1'b1; mem_sel = s; mem_addr = AW'(a);
      @(negedge clk);
      d = mem_rdata;
      mem_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [31:0] v;
      int          k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", reg_rdata, 32'h0);
      check("R1", mem_rdata, 32'h0);

      reg_read(2'd0, v); check("R1", v, 32'h1);
      reg_read(2'd1, v); check("R1", v, 32'h5);
      reg_read(2'd2, v); check("R6", v, CFG_EXP);
      reg_read(2'd3, v); check("R10", v, 32'h0);

      // host access while held and not scrubbing
      mem_write(1'b0, 5, 32'hA5A5_0005);
      mem_write(1'b0, 1000, 32'h1234_5678);
      mem_write(1'b1, 7, 32'hBEEF_0007);
      mem_read(1'b0, 5, v);  check("R8", v, 32'hA5A5_0005);
      mem_read(1'b1, 7, v);  check("R8", v, 32'hBEEF_0007);
      reg_read(2'd1, v);     check("R9", v, 32'h4);
      idle(1);
      reg_read(2'd1, v);     check("R9", v, 32'h5);
      mem_write(1'b1, 600, 32'hDEAD_0600);
      mem_read(1'b1, 600, v); check("R8", v, 32'h0);

      // release, then act during the scrub, then stop it part way
      reg_write(2'd0, 32'h0);
      reg_read(2'd1, v);     check("R9", v, 32'h4);
      mem_write(1'b1, 300, 32'h0BAD_0300);
      mem_read(1'b1, 300, v); check("R7", v, 32'h0);
      mem_read(1'b0, 1000, v); check("R7", v, 32'h0);
      idle(50);
      reg_write(2'd0, 32'h1);
      reg_read(2'd1, v);     check("R5", v, 32'h5);
      reg_read(2'd0, v);     check("R5", v, 32'h1);
      mem_read(1'b0, 1000, v); check("R5", v, 32'h1234_5678);
      mem_read(1'b0, 5, v);  check("R5", v, 32'h0);

      // full scrub and its timing
      reg_write(2'd0, 32'h0);
      k = 0;
      v = '0;
      while (!v[1] && k < 5000) begin
         reg_read(2'd1, v);
         k++;
      end
      check("R4", 32'(k), 32'(NSCR + 1));
      mem_read(1'b0, 1000, v);   check("R4", v, 32'h0);
      mem_read(1'b1, 7, v);      check("R4", v, 32'h0);
      mem_read(1'b0, ID - 1, v); check("R4", v, 32'h0);
      mem_read(1'b1, DD - 1, v); check("R4", v, 32'h0);

      // releasing again while released does nothing
      reg_write(2'd0, 32'h0);
      reg_read(2'd1, v); check("R2", v, 32'h7);
      idle(3);
      reg_read(2'd1, v); check("R2", v, 32'h7);

      // normal access after the scrub
      mem_write(1'b0, 3, 32'h0000_C0DE);
      mem_read(1'b0, 3, v);   check("R8", v, 32'h0000_C0DE);
      mem_write(1'b1, DD - 1, 32'h5555_AAAA);
      mem_read(1'b1, DD - 1, v); check("R8", v, 32'h5555_AAAA);

      // hold accepted while ready is low
      mem_read(1'b0, 3, v);
      reg_write(2'd0, 32'h1);
      reg_read(2'd0, v); check("R2", v, 32'h1);
      reg_read(2'd1, v); check("R3", v, 32'h5);

      idle(2);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule